// File: doc/BRIEF.md
# Word-Crossing Load/Store Adapter

This block sits between a load/store requester and a memory port that is one word wide. Each request carries a byte address, a size of 1, 2, 4 or 8 bytes (a 2-bit code holding log2 of the size), a read/write flag and write data. The block checks whether the address is naturally aligned for that size. It then handles the access according to a 2-bit policy that is sampled when the request is accepted.

Under the split policy, a datum whose first and last bytes sit in different words is carried out as two word beats. The lower-addressed word goes first. Read bytes are stitched together in little-endian order, and write beats carry byte enables that cover only the datum's bytes. Under the round-down policy, the low address bits are cleared so that the access becomes aligned. Under the fault policies, a misaligned request is answered with a fault and does not reach memory.

The requester sees a ready/valid handshake. Every accepted request produces exactly one response pulse. Memory requests use a valid/ready handshake, and memory returns one response pulse per beat after a fixed latency. The word width and address width are parameters. Datum and word are the same width, and in the default configuration both are 8 bytes.

Top module: `misaligned_access_unit`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and mem_req_valid is 0.
- R2: An access whose address is a multiple of its size (size = 1 << req_size) is done in exactly one memory beat at the word address (low 3 bits zero) under any policy. A read returns the datum's bytes in little-endian order, zero-filled above the size.
- R3: A 1-byte access (req_size = 0) never faults and never splits, under any policy.
- R4: Under policy 2'b00 (split), an access whose lowest and highest bytes lie in different words takes two beats. The first beat goes to the lower word address and the second to that address + 8. The read result is the little-endian assembly of the bytes at req_addr .. req_addr+size-1.
- R5: Write beats enable only the bytes belonging to the datum. All other bytes of both words keep their old contents.
- R6: Under policy 2'b00, a misaligned access that stays inside one word takes a single beat.
- R7: Under policy 2'b01 (round-down), the effective address is req_addr with its low req_size bits cleared, and the access takes a single beat.
- R8: Under policy 2'b10 or 2'b11 (fault), a misaligned request gets resp_valid with resp_fault = 1, issues no memory beat and leaves memory unchanged.
- R9: req_ready stays 0 from acceptance until the response. Each request yields exactly one single-cycle resp_valid pulse.
- R10: cfg_policy is sampled only at acceptance. Changing it while an access is in progress has no effect on that access.
- R11: While mem_req_valid is high and mem_req_ready is low, mem_req_valid, mem_addr and mem_be hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of access size in bytes |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write datum, little-endian, low bytes used |
| cfg_policy | input | 2 | 00 split, 01 round-down, 10/11 fault |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_fault | output | 1 | Misalignment fault reported |
| resp_rdata | output | 64 | Read datum, zero above the size |
| mem_req_valid | output | 1 | Memory beat request |
| mem_req_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | ADDR_W | Word-aligned byte address of the beat |
| mem_we | output | 1 | Beat is a write |
| mem_be | output | 8 | Per-byte write enables |
| mem_wdata | output | 64 | Beat write data, lane aligned |
| mem_rvalid | input | 1 | Beat completed (read data valid) |
| mem_rdata | input | 64 | Beat read data |

## Verification
Random requests draw address, size, direction and policy over a small address window. This mixes aligned accesses, misaligned accesses inside one word and word-crossing accesses, so each policy is seen on every alignment class. Directed cases pin down the boundaries:
- a crossing at the last byte of a word, which separates the split path from the in-word misaligned path;
- byte accesses at odd offsets under the fault policy;
- a rounded address versus the raw one;
- a fault on a write, followed by a read-back that shows memory untouched.

Beat counts and beat addresses separate one-beat from two-beat handling and show the order of the two words. Aligned read-back of the neighbouring words shows whether the byte enables were too wide. A policy change in the middle of a split access tells whether the policy is sampled only at acceptance.

// File: rtl/mah_pkg.sv
package mah_pkg;
  typedef enum logic [1:0] {
    POL_SPLIT     = 2'b00,
    POL_ROUND     = 2'b01,
    POL_FAULT     = 2'b10,
    POL_FAULT_ALT = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_ISSUE = 2'b01,
    S_WAIT  = 2'b10,
    S_DONE  = 2'b11
  } state_e;
endpackage

// File: rtl/mah_align.sv
module mah_align #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8,
  localparam int OFF_W     = $clog2(WORD_BYTES),
  localparam int SIZE_W    = $clog2(OFF_W + 1),
  localparam int NB_W      = OFF_W + 1
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SIZE_W-1:0]   size,
  input  mah_pkg::policy_e    policy,
  output logic                misaligned,
  output logic                crosses,
  output logic                fault,
  output logic [ADDR_W-1:0]   eff_addr
);
  import mah_pkg::*;

  logic [ADDR_W-1:0] low_mask;
  logic [NB_W-1:0]   nbytes;
  logic [NB_W-1:0]   last_off;

  // mask of the bits that must be zero for natural alignment
  always_comb begin
    low_mask   = (ADDR_W'(1) << size) - ADDR_W'(1);
    nbytes     = NB_W'(1) << size;
    misaligned = |(addr & low_mask);
    fault      = misaligned && (policy == POL_FAULT || policy == POL_FAULT_ALT);
    eff_addr   = (policy == POL_ROUND) ? (addr & ~low_mask) : addr;
    // offset of the datum's top byte; carry into bit OFF_W means next word
    last_off   = {1'b0, eff_addr[OFF_W-1:0]} + nbytes - NB_W'(1);
    crosses    = last_off[OFF_W];
  end
endmodule

// File: rtl/mah_lanes.sv
module mah_lanes #(
  parameter int WORD_BYTES = 8,
  localparam int OFF_W     = $clog2(WORD_BYTES),
  localparam int SIZE_W    = $clog2(OFF_W + 1),
  localparam int NB_W      = OFF_W + 1,
  localparam int DATA_W    = 8 * WORD_BYTES
) (
  input  logic [OFF_W-1:0]      off,
  input  logic [SIZE_W-1:0]     size,
  input  logic [DATA_W-1:0]     wdata,
  output logic [WORD_BYTES-1:0] be_lo,
  output logic [WORD_BYTES-1:0] be_hi,
  output logic [DATA_W-1:0]     wd_lo,
  output logic [DATA_W-1:0]     wd_hi
);
  logic [NB_W-1:0]         nbytes;
  logic [WORD_BYTES-1:0]   size_mask;
  logic [2*WORD_BYTES-1:0] be_wide;
  logic [2*DATA_W-1:0]     wd_wide;

  assign nbytes = NB_W'(1) << size;

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_mask
    assign size_mask[i] = (NB_W'(i) < nbytes);
  end

  // slide the datum into a two-word window, then cut it into beats
  assign be_wide = {{WORD_BYTES{1'b0}}, size_mask} << off;
  assign wd_wide = {{DATA_W{1'b0}}, wdata} << {off, 3'b000};

  assign be_lo = be_wide[WORD_BYTES-1:0];
  assign be_hi = be_wide[2*WORD_BYTES-1:WORD_BYTES];
  assign wd_lo = wd_wide[DATA_W-1:0];
  assign wd_hi = wd_wide[2*DATA_W-1:DATA_W];
endmodule

// File: rtl/mah_merge.sv
module mah_merge #(
  parameter int WORD_BYTES = 8,
  localparam int OFF_W     = $clog2(WORD_BYTES),
  localparam int SIZE_W    = $clog2(OFF_W + 1),
  localparam int NB_W      = OFF_W + 1,
  localparam int DATA_W    = 8 * WORD_BYTES
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] rd_lo,
  input  logic [DATA_W-1:0] rd_hi,
  output logic [DATA_W-1:0] rdata
);
  logic [NB_W-1:0]     nbytes;
  logic [2*DATA_W-1:0] wide;

  assign nbytes = NB_W'(1) << size;
  // little-endian: lower word supplies the low bytes
  assign wide   = {rd_hi, rd_lo} >> {off, 3'b000};

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_byte
    assign rdata[i*8 +: 8] = (NB_W'(i) < nbytes) ? wide[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/misaligned_access_unit.sv
module misaligned_access_unit #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8,
  localparam int OFF_W     = $clog2(WORD_BYTES),
  localparam int SIZE_W    = $clog2(OFF_W + 1),
  localparam int DATA_W    = 8 * WORD_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [SIZE_W-1:0]     req_size,
  input  logic                  req_we,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [1:0]            cfg_policy,
  output logic                  resp_valid,
  output logic                  resp_fault,
  output logic [DATA_W-1:0]     resp_rdata,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_we,
  output logic [WORD_BYTES-1:0] mem_be,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic                  mem_rvalid,
  input  logic [DATA_W-1:0]     mem_rdata
);
  import mah_pkg::*;

  state_e              state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [SIZE_W-1:0]   size_q;
  logic                we_q;
  logic                cross_q;
  logic                beat_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rd_lo_q;
  logic [DATA_W-1:0]   rd_hi_q;
  logic                resp_valid_q;
  logic                resp_fault_q;
  logic [DATA_W-1:0]   resp_rdata_q;

  logic                chk_misaligned;
  logic                chk_crosses;
  logic                chk_fault;
  logic [ADDR_W-1:0]   chk_eff;
  logic [WORD_BYTES-1:0] be_lo, be_hi;
  logic [DATA_W-1:0]   wd_lo, wd_hi;
  logic [DATA_W-1:0]   merged;
  logic [ADDR_W-1:0]   word_base;
  logic                accept;

  // classification of the incoming request, policy taken live here only
  mah_align #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_align (
    .addr       (req_addr),
    .size       (req_size),
    .policy     (policy_e'(cfg_policy)),
    .misaligned (chk_misaligned),
    .crosses    (chk_crosses),
    .fault      (chk_fault),
    .eff_addr   (chk_eff)
  );

  mah_lanes #(.WORD_BYTES(WORD_BYTES)) u_lanes (
    .off   (addr_q[OFF_W-1:0]),
    .size  (size_q),
    .wdata (wdata_q),
    .be_lo (be_lo),
    .be_hi (be_hi),
    .wd_lo (wd_lo),
    .wd_hi (wd_hi)
  );

  mah_merge #(.WORD_BYTES(WORD_BYTES)) u_merge (
    .off   (addr_q[OFF_W-1:0]),
    .size  (size_q),
    .rd_lo (rd_lo_q),
    .rd_hi (rd_hi_q),
    .rdata (merged)
  );

  assign accept    = req_valid && (state_q == S_IDLE);
  assign word_base = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      addr_q       <= '0;
      size_q       <= '0;
      we_q         <= 1'b0;
      cross_q      <= 1'b0;
      beat_q       <= 1'b0;
      wdata_q      <= '0;
      rd_lo_q      <= '0;
      rd_hi_q      <= '0;
      resp_valid_q <= 1'b0;
      resp_fault_q <= 1'b0;
      resp_rdata_q <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            addr_q  <= chk_eff;
            size_q  <= req_size;
            we_q    <= req_we;
            cross_q <= chk_crosses;
            wdata_q <= req_wdata;
            beat_q  <= 1'b0;
            rd_lo_q <= '0;
            rd_hi_q <= '0;
            if (chk_fault) begin
              resp_valid_q <= 1'b1;
              resp_fault_q <= 1'b1;
              resp_rdata_q <= '0;
            end else begin
              state_q <= S_ISSUE;
            end
          end
        end
        S_ISSUE: begin
          if (mem_req_ready) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rvalid) begin
            if (beat_q) rd_hi_q <= mem_rdata;
            else        rd_lo_q <= mem_rdata;
            if (cross_q && !beat_q) begin
              beat_q  <= 1'b1;
              state_q <= S_ISSUE;
            end else begin
              state_q <= S_DONE;
            end
          end
        end
        S_DONE: begin
          resp_valid_q <= 1'b1;
          resp_fault_q <= 1'b0;
          resp_rdata_q <= we_q ? '0 : merged;
          state_q      <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign resp_valid    = resp_valid_q;
  assign resp_fault    = resp_fault_q;
  assign resp_rdata    = resp_rdata_q;
  assign mem_req_valid = (state_q == S_ISSUE);
  assign mem_addr      = word_base + (beat_q ? ADDR_W'(WORD_BYTES) : '0);
  assign mem_we        = we_q;
  assign mem_be        = beat_q ? be_hi : be_lo;
  assign mem_wdata     = beat_q ? wd_hi : wd_lo;

  // R9: no memory beat while the block advertises readiness
  p_busy_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  // R9: response is a single-cycle pulse
  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R11: stalled beat holds its address and enables
  p_beat_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_be)));

  // R2: beats always target a whole word
  p_word_addr_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_addr[OFF_W-1:0] == '0));

  // R5: every beat enables at least one byte of the datum
  p_be_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_be != '0));

  // R3: a byte access always proceeds to memory
  p_byte_goes_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_size == '0) |=> mem_req_valid);

  // R8: a faulting request answers at once and never touches memory
  p_fault_nomem_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && chk_misaligned && cfg_policy[1]) |=>
      (resp_valid && resp_fault && !mem_req_valid));
endmodule

// File: tb/misaligned_access_unit_tb.sv
module misaligned_access_unit_tb;
  localparam int AW  = 32;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_we = 1'b0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  cfg_policy = 2'b00;
  logic        resp_valid, resp_fault;
  logic [63:0] resp_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [AW-1:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic        mem_rvalid;
  logic [63:0] mem_rdata;

  always #5 clk = ~clk;

  misaligned_access_unit #(.ADDR_W(AW), .WORD_BYTES(8)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_we(req_we), .req_wdata(req_wdata),
    .cfg_policy(cfg_policy),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_rdata(resp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // ---------------- memory model: fixed latency, periodic stalls --------
  logic [63:0]   bmem [64];
  logic [LAT-1:0] vpipe;
  logic [63:0]   dpipe [LAT];
  int unsigned   beat_cnt;
  logic [AW-1:0] hs_addr [16];
  int unsigned   cyc;

  assign mem_req_ready = (cyc % 3) != 1;
  assign mem_rvalid    = vpipe[LAT-1];
  assign mem_rdata     = dpipe[LAT-1];

  function automatic logic [7:0] init_byte(int k);
    return 8'(k * 7 + 3);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int w = 0; w < 64; w++)
        for (int b = 0; b < 8; b++) bmem[w][b*8 +: 8] <= init_byte(w*8 + b);
      vpipe    <= '0;
      beat_cnt <= 0;
      for (int k = 0; k < LAT; k++) dpipe[k] <= '0;
    end else begin
      vpipe <= {vpipe[LAT-2:0], mem_req_valid && mem_req_ready};
      for (int k = 1; k < LAT; k++) dpipe[k] <= dpipe[k-1];
      dpipe[0] <= '0;
      if (mem_req_valid && mem_req_ready) begin
        hs_addr[beat_cnt[3:0]] <= mem_addr;
        beat_cnt <= beat_cnt + 1;
        if (mem_we) begin
          for (int b = 0; b < 8; b++)
            if (mem_be[b]) bmem[mem_addr[8:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end else begin
          dpipe[0] <= bmem[mem_addr[8:3]];
        end
      end
    end
  end

  // R11 monitor: stalled beat must not change
  int unsigned   hold_fail = 0;
  int unsigned   hold_chk  = 0;
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_addr  = '0;
  always @(negedge clk) begin
    if (!rst && prev_stall) begin
      hold_chk <= hold_chk + 1;
      if (!mem_req_valid || mem_addr != prev_addr) hold_fail <= hold_fail + 1;
    end
    prev_stall <= !rst && mem_req_valid && !mem_req_ready;
    prev_addr  <= mem_addr;
  end

  // ---------------- reference and checking -------------------------------
  logic [7:0] ref_mem [512];
  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_access(input logic [AW-1:0] a, input logic [1:0] sz,
                           input bit we, input logic [63:0] wd,
                           input logic [1:0] pol, input bit flip_pol,
                           input string req);
    int unsigned n = 1 << sz;
    bit mis = (a & (n - 1)) != 0;
    bit ef  = mis && pol[1];
    logic [AW-1:0] eff = (pol == 2'b01) ? (a & ~AW'(n - 1)) : a;
    int unsigned eb = ef ? 0 : (((eff % 8) + n > 8) ? 2 : 1);
    logic [63:0] ed = '0;
    int unsigned base, guard, ready_bad;
    for (int i = 0; i < 8; i++)
      if (i < n) ed[i*8 +: 8] = ref_mem[(eff + i) % 512];
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_we = we;
    req_wdata = wd; cfg_policy = pol;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    base = beat_cnt;
    if (flip_pol) cfg_policy = ~pol;
    guard = 0; ready_bad = 0;
    while (!resp_valid && guard < 1000) begin
      if (req_ready) ready_bad++;
      guard++;
      @(negedge clk);
    end
    if (guard >= 1000) begin
      chk(1'b0, {req, " watchdog"}, 64'(guard), 64'd0);
      return;
    end
    chk(ready_bad == 0, "R9 ready low while busy", 64'(ready_bad), 64'd0);
    chk(resp_fault == ef, {req, " fault"}, 64'(resp_fault), 64'(ef));
    chk(beat_cnt - base == eb, {req, " beats"}, 64'(beat_cnt - base), 64'(eb));
    if (eb >= 1)
      chk(hs_addr[base[3:0]] == (eff & ~AW'(7)), {req, " first beat addr"},
          64'(hs_addr[base[3:0]]), 64'(eff & ~AW'(7)));
    if (eb == 2)
      chk(hs_addr[4'(base + 1)] == (eff & ~AW'(7)) + 8, {req, " second beat addr"},
          64'(hs_addr[4'(base + 1)]), 64'((eff & ~AW'(7)) + 8));
    if (!we && !ef)
      chk(resp_rdata == ed, {req, " read data"}, resp_rdata, ed);
    @(negedge clk);
    chk(!resp_valid, "R9 single pulse", 64'(resp_valid), 64'd0);
    if (we && !ef)
      for (int i = 0; i < 8; i++)
        if (i < n) ref_mem[(eff + i) % 512] = wd[i*8 +: 8];
    if (flip_pol) cfg_policy = pol;
  endtask

  initial begin
    for (int k = 0; k < 512; k++) ref_mem[k] = init_byte(k);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    chk(resp_valid == 1'b0, "R1 resp_valid", 64'(resp_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);

    // R2: aligned accesses under each policy
    do_access(32'h40, 2'd3, 1'b0, '0, 2'b00, 1'b0, "R2 aligned d split");
    do_access(32'h44, 2'd2, 1'b0, '0, 2'b10, 1'b0, "R2 aligned w fault");
    do_access(32'h46, 2'd1, 1'b1, 64'hBEEF, 2'b01, 1'b0, "R2 aligned h write");
    do_access(32'h40, 2'd3, 1'b0, '0, 2'b00, 1'b0, "R2 readback");
    // R3: byte access at odd offsets never faults
    do_access(32'h47, 2'd0, 1'b0, '0, 2'b10, 1'b0, "R3 byte fault pol");
    do_access(32'h4F, 2'd0, 1'b1, 64'h5A, 2'b11, 1'b0, "R3 byte alt pol");
    do_access(32'h49, 2'd0, 1'b0, '0, 2'b01, 1'b0, "R3 byte round pol");
    // R4: crossing reads, including the last-byte crossing
    do_access(32'h46, 2'd2, 1'b0, '0, 2'b00, 1'b0, "R4 split w");
    do_access(32'h5F, 2'd1, 1'b0, '0, 2'b00, 1'b0, "R4 split h edge");
    do_access(32'h61, 2'd3, 1'b0, '0, 2'b00, 1'b0, "R4 split d");
    // R5: crossing write, then neighbours read back whole
    do_access(32'h83, 2'd3, 1'b1, 64'h1122334455667788, 2'b00, 1'b0, "R5 split write");
    do_access(32'h80, 2'd3, 1'b0, '0, 2'b00, 1'b0, "R5 low word");
    do_access(32'h88, 2'd3, 1'b0, '0, 2'b00, 1'b0, "R5 high word");
    // R6: misaligned within one word
    do_access(32'h91, 2'd1, 1'b0, '0, 2'b00, 1'b0, "R6 inword h");
    do_access(32'h92, 2'd2, 1'b1, 64'hCAFEF00D, 2'b00, 1'b0, "R6 inword w write");
    do_access(32'h90, 2'd3, 1'b0, '0, 2'b00, 1'b0, "R6 readback");
    // R7: round-down
    do_access(32'hA3, 2'd2, 1'b0, '0, 2'b01, 1'b0, "R7 round w");
    do_access(32'hAF, 2'd3, 1'b1, 64'h0102030405060708, 2'b01, 1'b0, "R7 round d write");
    do_access(32'hA8, 2'd3, 1'b0, '0, 2'b00, 1'b0, "R7 readback");
    // R8: faults, memory untouched
    do_access(32'hC2, 2'd2, 1'b1, 64'hFFFFFFFF, 2'b10, 1'b0, "R8 fault write");
    do_access(32'hC7, 2'd3, 1'b1, 64'h0, 2'b11, 1'b0, "R8 fault alt write");
    do_access(32'hC0, 2'd3, 1'b0, '0, 2'b00, 1'b0, "R8 readback lo");
    do_access(32'hC8, 2'd3, 1'b0, '0, 2'b00, 1'b0, "R8 readback hi");
    // R10: policy flipped during a split access
    do_access(32'hD5, 2'd3, 1'b0, '0, 2'b00, 1'b1, "R10 flip split");
    do_access(32'hE6, 2'd2, 1'b0, '0, 2'b01, 1'b1, "R10 flip round");

    // random mix over all policies and sizes
    void'($urandom(32'd20240611));
    for (int t = 0; t < 400; t++) begin
      logic [AW-1:0] ra = AW'($urandom_range(0, 495));
      logic [1:0]    rs = 2'($urandom_range(0, 3));
      bit            rw = 1'($urandom_range(0, 1));
      logic [63:0]   rd = {$urandom, $urandom};
      logic [1:0]    rp = 2'($urandom_range(0, 3));
      do_access(ra, rs, rw, rd, rp, 1'b0, "R4/R7/R8 random");
    end

    chk(hold_fail == 0 && hold_chk > 0, "R11 stalled beat stable",
        64'(hold_fail), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule